// File: doc/BRIEF.md
# Parallel Float Absolute-Value and Store Unit

This unit executes one paired instruction per issue. One half loads a single-precision word from memory through an indirect address, forms its floating-point absolute value and writes the 40-bit result into one of eight extended-precision registers. The other half takes a second register, packs it into the 32-bit single-precision word format and writes it to memory at a second indirect address. Both addresses come from an auxiliary register plus or minus a displacement of zero, one, or one of two index registers.

The unit sits in the execute stage of a processor core. The core presents the instruction word, the current register contents, the auxiliary and index registers, and the current status word. The unit drives the read address combinationally and takes the read data back in the same cycle. All operands are captured on the clock edge that accepts the instruction. The register write, the memory write and the new status word come out together one cycle later. Because nothing is written before every operand has been sampled, an operand that aliases a destination always yields its old value.

Register format: bits 39:32 hold a two's-complement exponent and bits 31:0 hold a two's-complement mantissa, with bit 31 as the sign. An exponent of 80h means zero. The memory word is {exponent[7:0], mantissa[31:8]}. A load fills the low 8 mantissa bits with zeros, and a store drops them.

Top module: `pabs_unit`

## Requirements
- R1: An instruction executes only when `issue_valid` is 1 and instr[31:26] equals 110010b. In every other cycle, `rf_we`, `mem_we` and `st_we` are 0 on the following cycle.
- R2: An accepted instruction commits the register write, the memory write and the status write together, all on the cycle after acceptance.
- R3: The instruction fields are dst1 = instr[24:22], src3 = instr[21:19], source operand = instr[15:8] and destination operand = instr[7:0]. In each 8-bit operand, bits 2:0 select auxiliary register ARn, bits 4:3 select the displacement (00 = 0, 01 = 1, 10 = IR0, 11 = IR1), and bit 5 subtracts the displacement when 1 and adds it when 0. `mem_raddr` and `mem_waddr` equal ARn plus or minus the displacement.
- R4: A source with a non-negative mantissa is written unchanged. A source with a negative mantissa, other than 80000000h, gets its mantissa negated in two's complement and keeps its exponent.
- R5: A source with exponent 7Fh and mantissa 80000000h saturates to exponent 7Fh and mantissa 7FFFFFFFh. This case sets V (status bit 1) and LV (status bit 5).
- R6: A source with mantissa 80000000h and an exponent other than 7Fh or 80h yields mantissa 0 and exponent + 1.
- R7: A source with exponent 80h yields exponent 80h and mantissa 0, and sets Z (status bit 2). For any other result, Z is 0.
- R8: When no overflow occurs, V is 0 and LV keeps its input value. N (bit 3) and UF (bit 4) are always cleared. LUF (bit 6) and C (bit 0) keep their input values.
- R9: The stored word is {R[src3][39:32], R[src3][31:8]}, using the register value present when the instruction is accepted, even if dst1 equals src3.
- R10: When the source and destination addresses are equal, the loaded value is the memory content from before this instruction's store.
- R11: While `rst_n` is 0, every write enable and every registered output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| rf_flat | input | 320 | R0..R7, 40 bits each, R0 in the low bits |
| aux_flat | input | 8*AW | AR0..AR7, AW bits each |
| ir0 | input | AW | Index register 0 |
| ir1 | input | AW | Index register 1 |
| st_in | input | 7 | Current status word |
| mem_raddr | output | AW | Source operand address (combinational) |
| mem_rdata | input | 32 | Source word read at mem_raddr |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 40 | Absolute-value result |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | AW | Store address |
| mem_wdata | output | 32 | Packed store word |
| st_we | output | 1 | Status write enable |
| st_out | output | 7 | New status word |

## Verification
The absolute-value path is driven with six kinds of source word: a positive value, an ordinary negative value, mantissa 80000000h at a mid-range exponent, the same mantissa at exponent 7Fh, and two zero encodings. Together these separate the pass-through, negate, exponent-bump, saturate and zero paths, and each kind also checks its own status pattern. All four displacement selections, in both add and subtract direction, are applied to both addresses, and non-matching opcodes are shown to produce no writes. Two aliasing cases, one on a register and one on a memory location, are followed by a read-back that shows the old value was used and the new value did land.

// File: rtl/pabs_pkg.sv
// Package: shared types, field layouts and word-format conversions for the
// parallel absolute-value/store unit. Assumes eight data registers and
// eight auxiliary registers (3-bit indices in the instruction).
package pabs_pkg;

    localparam int EXP_W  = 8;
    localparam int MAN_W  = 32;
    localparam int XW     = EXP_W + MAN_W;
    localparam int SW     = 32;
    localparam int NREG   = 8;
    localparam int NAUX   = 8;
    localparam int RIDX_W = $clog2(NREG);
    localparam int STW    = 7;

    localparam logic [5:0]       OPC_PABS = 6'b110010;
    localparam logic [EXP_W-1:0] EXP_ZERO = 8'h80;
    localparam logic [EXP_W-1:0] EXP_MAX  = 8'h7F;
    localparam logic [MAN_W-1:0] MAN_MIN  = 32'h8000_0000;
    localparam logic [MAN_W-1:0] MAN_MAX  = 32'h7FFF_FFFF;

    typedef struct packed {
        logic [EXP_W-1:0] e;
        logic [MAN_W-1:0] m;
    } xfloat_t;

    // Status layout, bit 6 down to bit 0.
    typedef struct packed {
        logic luf;
        logic lv;
        logic uf;
        logic n;
        logic z;
        logic v;
        logic c;
    } stat_t;

    typedef enum logic [1:0] {
        DSEL_ZERO = 2'b00,
        DSEL_ONE  = 2'b01,
        DSEL_IX0  = 2'b10,
        DSEL_IX1  = 2'b11
    } dsel_e;

    typedef struct packed {
        logic [1:0]  rsv;
        logic        sub;
        dsel_e       dsel;
        logic [2:0]  ar;
    } memop_t;

    typedef struct packed {
        logic [5:0]        opc;
        logic              rsv_a;
        logic [RIDX_W-1:0] dst_reg;
        logic [RIDX_W-1:0] src_reg;
        logic [2:0]        rsv_b;
        memop_t            ld_op;
        memop_t            st_op;
    } instr_t;

    // Expand a memory word into register format (low mantissa bits zero).
    function automatic xfloat_t word_to_x(input logic [SW-1:0] w);
        xfloat_t r;
        r.e = w[SW-1 -: EXP_W];
        r.m = {w[SW-EXP_W-1:0], {(MAN_W-(SW-EXP_W)){1'b0}}};
        return r;
    endfunction

    // Pack a register value into memory word format (low mantissa bits dropped).
    function automatic logic [SW-1:0] x_to_word(input xfloat_t x);
        return {x.e, x.m[MAN_W-1 -: (SW-EXP_W)]};
    endfunction

endpackage

// File: rtl/pabs_eagen.sv
// Effective-address generator: selected auxiliary register plus or minus a
// displacement of 0, 1, IR0 or IR1. Purely combinational; assumes the
// auxiliary registers are presented flat, AR0 in the low bits.
module pabs_eagen
    import pabs_pkg::*;
#(
    parameter int AW = 24
) (
    input  memop_t             op,
    input  logic [NAUX*AW-1:0] aux_flat,
    input  logic [AW-1:0]      ir0,
    input  logic [AW-1:0]      ir1,
    output logic [AW-1:0]      ea
);

    localparam logic [AW-1:0] DISP_ONE = AW'(1);

    logic [AW-1:0] base;
    logic [AW-1:0] disp;

    // Pick the base auxiliary register.
    always_comb begin
        base = aux_flat[op.ar*AW +: AW];
    end

    // Pick the displacement by selector code.
    always_comb begin
        unique case (op.dsel)
            DSEL_ZERO: disp = '0;
            DSEL_ONE:  disp = DISP_ONE;
            DSEL_IX0:  disp = ir0;
            DSEL_IX1:  disp = ir1;
            default:   disp = '0;
        endcase
    end

    // Apply the displacement in the requested direction.
    always_comb begin
        ea = op.sub ? (base - disp) : (base + disp);
    end

endmodule

// File: rtl/pabs_absunit.sv
// Floating-point absolute value on a two's-complement mantissa. Handles the
// zero encoding, the most-negative mantissa (exponent bump), and the
// saturating overflow at maximum exponent. Combinational.
module pabs_absunit
    import pabs_pkg::*;
(
    input  xfloat_t src,
    output xfloat_t res,
    output logic    ovf,
    output logic    is_zero
);

    logic src_zero;
    logic src_min;
    logic src_top;

    // Classify the source.
    always_comb begin
        src_zero = (src.e == EXP_ZERO);
        src_min  = (src.m == MAN_MIN);
        src_top  = (src.e == EXP_MAX);
    end

    // Produce the result for each class.
    always_comb begin
        ovf = 1'b0;
        res = src;
        if (src_zero) begin
            res.e = EXP_ZERO;
            res.m = '0;
        end else if (src_min && src_top) begin
            res.e = EXP_MAX;
            res.m = MAN_MAX;
            ovf   = 1'b1;
        end else if (src_min) begin
            res.e = src.e + 8'd1;
            res.m = '0;
        end else if (src.m[MAN_W-1]) begin
            res.m = (~src.m) + 32'd1;
        end
    end

    // Zero detection on the result.
    always_comb begin
        is_zero = (res.e == EXP_ZERO);
    end

endmodule

// File: rtl/pabs_flags.sv
// Status update: V/LV from overflow, Z from a zero result, N and UF cleared,
// LUF and C carried through. Combinational.
module pabs_flags
    import pabs_pkg::*;
(
    input  stat_t cur,
    input  logic  ovf,
    input  logic  is_zero,
    output stat_t nxt
);

    // Form the next status word.
    always_comb begin
        nxt     = cur;
        nxt.v   = ovf;
        nxt.lv  = cur.lv | ovf;
        nxt.z   = is_zero;
        nxt.n   = 1'b0;
        nxt.uf  = 1'b0;
    end

endmodule

// File: rtl/pabs_unit.sv
// Top: parallel absolute-value/store execution unit. Decodes the instruction,
// generates both indirect addresses, computes the absolute value of the
// loaded word and packs the store word, then commits all results on one
// edge. Every operand is taken from the inputs at the accepting edge, so an
// aliased operand always sees its pre-instruction value.
module pabs_unit
    import pabs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [31:0]          instr,
    input  logic [NREG*XW-1:0]   rf_flat,
    input  logic [NAUX*AW-1:0]   aux_flat,
    input  logic [AW-1:0]        ir0,
    input  logic [AW-1:0]        ir1,
    input  logic [STW-1:0]       st_in,
    output logic [AW-1:0]        mem_raddr,
    input  logic [SW-1:0]        mem_rdata,
    output logic                 rf_we,
    output logic [RIDX_W-1:0]    rf_waddr,
    output logic [XW-1:0]        rf_wdata,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_waddr,
    output logic [SW-1:0]        mem_wdata,
    output logic                 st_we,
    output logic [STW-1:0]       st_out
);

    localparam int NPORT = 2;
    localparam int LD    = 0;
    localparam int ST    = 1;

    instr_t          ins;
    logic            fire;
    memop_t          ops [NPORT];
    logic [AW-1:0]   eas [NPORT];
    xfloat_t         ld_x;
    xfloat_t         abs_x;
    logic            abs_ovf;
    logic            abs_zero;
    xfloat_t         st_x;
    logic [SW-1:0]   st_word;
    stat_t           st_next;

    // Decode and acceptance.
    always_comb begin
        ins     = instr_t'(instr);
        fire    = issue_valid && (ins.opc == OPC_PABS);
        ops[LD] = ins.ld_op;
        ops[ST] = ins.st_op;
    end

    // One address generator per memory operand.
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_ea
        pabs_eagen #(.AW(AW)) u_ea (
            .op       (ops[gi]),
            .aux_flat (aux_flat),
            .ir0      (ir0),
            .ir1      (ir1),
            .ea       (eas[gi])
        );
    end

    // Drive the read address straight from the source operand.
    always_comb begin
        mem_raddr = eas[LD];
    end

    // Load-path format conversion.
    always_comb begin
        ld_x = word_to_x(mem_rdata);
    end

    pabs_absunit u_abs (
        .src     (ld_x),
        .res     (abs_x),
        .ovf     (abs_ovf),
        .is_zero (abs_zero)
    );

    pabs_flags u_flags (
        .cur     (stat_t'(st_in)),
        .ovf     (abs_ovf),
        .is_zero (abs_zero),
        .nxt     (st_next)
    );

    // Store-path register pick and packing.
    always_comb begin
        st_x    = xfloat_t'(rf_flat[ins.src_reg*XW +: XW]);
        st_word = x_to_word(st_x);
    end

    // Commit enables: one pulse per accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we  <= 1'b0;
            mem_we <= 1'b0;
            st_we  <= 1'b0;
        end else begin
            rf_we  <= fire;
            mem_we <= fire;
            st_we  <= fire;
        end
    end

    // Result registers: loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_waddr  <= '0;
            rf_wdata  <= '0;
            mem_waddr <= '0;
            mem_wdata <= '0;
            st_out    <= '0;
        end else if (fire) begin
            rf_waddr  <= ins.dst_reg;
            rf_wdata  <= abs_x;
            mem_waddr <= eas[ST];
            mem_wdata <= st_word;
            st_out    <= st_next;
        end
    end

endmodule

// File: rtl/pabs_unit_chk.sv
// Checker for pabs_unit: temporal properties over its ports, bound below.
module pabs_unit_chk
    import pabs_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic [31:0]     instr,
    input logic [STW-1:0]  st_in,
    input logic            rf_we,
    input logic [XW-1:0]   rf_wdata,
    input logic            mem_we,
    input logic            st_we,
    input logic [STW-1:0]  st_out
);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && instr[31:26] == 6'b110010) |=> (!rf_we && !mem_we && !st_we));

    p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && instr[31:26] == 6'b110010) |=> (rf_we && mem_we && st_we));

    p_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rf_we, mem_we, st_we}) != 1 && $countones({rf_we, mem_we, st_we}) != 2);

    p_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !rf_wdata[31]);

    p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_out[1]) |-> (st_out[5] && rf_wdata == {8'h7F, 32'h7FFF_FFFF}));

    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (st_out[2] == (rf_wdata[39:32] == 8'h80)));

    p_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (!st_out[3] && !st_out[4]));

    p_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && $past(rst_n)) |-> (st_out[6] == $past(st_in[6]) && st_out[0] == $past(st_in[0])));

endmodule

bind pabs_unit pabs_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .instr       (instr),
    .st_in       (st_in),
    .rf_we       (rf_we),
    .rf_wdata    (rf_wdata),
    .mem_we      (mem_we),
    .st_we       (st_we),
    .st_out      (st_out)
);

// File: tb/pabs_unit_tb.sv
// Directed bench for pabs_unit: one task per scenario, each self-checking.
module pabs_unit_tb;

    localparam int AW = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_valid = 1'b0;
    logic [31:0]       instr = '0;
    logic [319:0]      rf_flat;
    logic [8*AW-1:0]   aux_flat;
    logic [AW-1:0]     ir0 = 24'd5;
    logic [AW-1:0]     ir1 = 24'd9;
    logic [6:0]        st_in = '0;
    logic [AW-1:0]     mem_raddr;
    logic [31:0]       mem_rdata;
    logic              rf_we;
    logic [2:0]        rf_waddr;
    logic [39:0]       rf_wdata;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [31:0]       mem_wdata;
    logic              st_we;
    logic [6:0]        st_out;

    logic [31:0] mem [256];
    logic [39:0] rf  [8];
    logic [AW-1:0] ar [8];
    logic        bw_en = 1'b0;
    logic [7:0]  bw_a  = '0;
    logic [31:0] bw_d  = '0;
    logic        br_en = 1'b0;
    logic [2:0]  br_a  = '0;
    logic [39:0] br_d  = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pabs_unit #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .rf_flat(rf_flat), .aux_flat(aux_flat), .ir0(ir0), .ir1(ir1),
        .st_in(st_in), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .st_we(st_we), .st_out(st_out)
    );

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            rf_flat[i*40 +: 40]  = rf[i];
            aux_flat[i*AW +: AW] = ar[i];
        end
    end

    assign mem_rdata = mem[mem_raddr[7:0]];

    // Memory and register-file models: bench pokes and design write-backs.
    always @(posedge clk) begin
        if (bw_en)  mem[bw_a] <= bw_d;
        if (mem_we) mem[mem_waddr[7:0]] <= mem_wdata;
        if (br_en)  rf[br_a] <= br_d;
        if (rf_we)  rf[rf_waddr] <= rf_wdata;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mop(input logic sub, input logic [1:0] ds, input logic [2:0] a);
        return {2'b00, sub, ds, a};
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] d1, input logic [2:0] s3,
                                       input logic [7:0] ld, input logic [7:0] st);
        return {6'b110010, 1'b0, d1, s3, 3'b000, ld, st};
    endfunction

    task automatic poke_mem(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bw_en = 1'b1; bw_a = a; bw_d = d;
        @(negedge clk); bw_en = 1'b0;
    endtask

    task automatic poke_rf(input logic [2:0] a, input logic [39:0] d);
        @(negedge clk); br_en = 1'b1; br_a = a; br_d = d;
        @(negedge clk); br_en = 1'b0;
    endtask

    // Present one instruction for one cycle; returns at the next negedge.
    task automatic issue(input logic [31:0] w);
        @(negedge clk); issue_valid = 1'b1; instr = w;
        @(negedge clk); issue_valid = 1'b0; instr = '0;
    endtask

    // Load a word at address 8'h40 via AR0, disp 0, into R1; store R7 to 8'h80 via AR1.
    task automatic run_abs(input string req, input logic [31:0] word, input logic [6:0] st,
                           input logic [39:0] exp_r, input logic [6:0] exp_s);
        poke_mem(8'h40, word);
        st_in = st;
        issue(mk(3'd1, 3'd7, mop(1'b0, 2'b00, 3'd0), mop(1'b0, 2'b00, 3'd1)));
        check({req, " result"}, {24'h0, rf_wdata}, {24'h0, exp_r});
        check({req, " status"}, {57'h0, st_out}, {57'h0, exp_s});
        check({req, " rf index"}, {61'h0, rf_waddr}, 64'd1);
    endtask

    task automatic t_reset();
        check("R11 rf_we", {63'h0, rf_we}, 64'd0);
        check("R11 mem_we", {63'h0, mem_we}, 64'd0);
        check("R11 st_we", {63'h0, st_we}, 64'd0);
        check("R11 data", {24'h0, rf_wdata}, 64'd0);
    endtask

    task automatic t_reject();
        poke_mem(8'h40, 32'h0540_0000);
        issue({6'b110011, 26'h0});
        check("R1 bad opcode", {61'h0, rf_we, mem_we, st_we}, 64'd0);
        @(negedge clk); instr = mk(3'd1, 3'd7, 8'h00, 8'h01); issue_valid = 1'b0;
        @(negedge clk); instr = '0;
        check("R1 valid low", {61'h0, rf_we, mem_we, st_we}, 64'd0);
        issue(mk(3'd1, 3'd7, 8'h00, 8'h01));
        check("R2 enables together", {61'h0, rf_we, mem_we, st_we}, 64'd7);
        @(negedge clk);
        check("R2 single pulse", {61'h0, rf_we, mem_we, st_we}, 64'd0);
    endtask

    task automatic t_values();
        run_abs("R4 positive/R8 keep", 32'h0540_0000, 7'b1111111, {8'h05, 32'h4000_0000}, 7'b1100001);
        run_abs("R4 negative", 32'h03C0_0000, 7'b0000000, {8'h03, 32'h4000_0000}, 7'b0000000);
        run_abs("R6 min mantissa", 32'h1080_0000, 7'b0000000, {8'h11, 32'h0000_0000}, 7'b0000000);
        run_abs("R5 overflow", 32'h7F80_0000, 7'b0000000, {8'h7F, 32'h7FFF_FFFF}, 7'b0100010);
        run_abs("R7 zero", 32'h8012_3456, 7'b0000000, {8'h80, 32'h0000_0000}, 7'b0000100);
        run_abs("R7 zero neg mant", 32'h80FF_0000, 7'b1000001, {8'h80, 32'h0000_0000}, 7'b1000101);
        run_abs("R8 lv kept no ovf", 32'h0C7F_FFFF, 7'b0100010, {8'h0C, 32'h7FFF_FF00}, 7'b0100000);
    endtask

    task automatic t_disp();
        for (int ds = 0; ds < 4; ds++) begin
            for (int sb = 0; sb < 2; sb++) begin
                logic [AW-1:0] dv;
                logic [AW-1:0] e_ld;
                logic [AW-1:0] e_st;
                dv   = (ds == 0) ? 24'd0 : (ds == 1) ? 24'd1 : (ds == 2) ? ir0 : ir1;
                e_ld = (sb == 1) ? ar[2] - dv : ar[2] + dv;
                e_st = (sb == 1) ? ar[5] - dv : ar[5] + dv;
                @(negedge clk);
                issue_valid = 1'b1;
                instr = mk(3'd0, 3'd7, mop(sb[0], ds[1:0], 3'd2), mop(sb[0], ds[1:0], 3'd5));
                #1;
                check($sformatf("R3 load addr ds%0d sub%0d", ds, sb), {40'h0, mem_raddr}, {40'h0, e_ld});
                @(negedge clk); issue_valid = 1'b0; instr = '0;
                check($sformatf("R3 store addr ds%0d sub%0d", ds, sb), {40'h0, mem_waddr}, {40'h0, e_st});
            end
        end
    endtask

    task automatic t_reg_alias();
        poke_rf(3'd2, {8'h09, 32'hA000_00CD});
        poke_mem(8'h40, 32'h0640_0000);
        issue(mk(3'd2, 3'd2, mop(1'b0, 2'b00, 3'd0), mop(1'b0, 2'b00, 3'd1)));
        check("R9 alias old value", {32'h0, mem_wdata}, {32'h0, 32'h09A0_0000});
        check("R9 abs written", {24'h0, rf_wdata}, {24'h0, 8'h06, 32'h4000_0000});
        @(negedge clk);
        issue(mk(3'd3, 3'd2, mop(1'b0, 2'b00, 3'd0), mop(1'b0, 2'b00, 3'd1)));
        check("R9 new value after", {32'h0, mem_wdata}, {32'h0, 32'h0640_0000});
    endtask

    task automatic t_mem_alias();
        poke_mem(8'h60, 32'h02C0_0000);
        poke_rf(3'd4, {8'h33, 32'h1234_5678});
        issue(mk(3'd5, 3'd4, mop(1'b0, 2'b00, 3'd6), mop(1'b0, 2'b00, 3'd6)));
        check("R10 load before store", {24'h0, rf_wdata}, {24'h0, 8'h02, 32'h4000_0000});
        check("R10 store word", {32'h0, mem_wdata}, {32'h0, 32'h3312_3456});
        @(negedge clk);
        issue(mk(3'd5, 3'd4, mop(1'b0, 2'b00, 3'd6), mop(1'b0, 2'b00, 3'd1)));
        check("R10 store landed", {24'h0, rf_wdata}, {24'h0, 8'h33, 32'h1234_5600});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) begin
            rf[i] = '0;
            ar[i] = 24'h20 + 24'(i);
        end
        ar[0] = 24'h40;
        ar[1] = 24'h80;
        ar[6] = 24'h60;
        rf[7] = {8'h01, 32'h1111_1111};
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reject();
        t_values();
        t_disp();
        t_reg_alias();
        t_mem_alias();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule